// File: doc/BRIEF.md
# Bidirectional Host Data Queue with Flag Interrupts

This block holds compressed data as 32-bit words between a host bus and a compression engine, in one direction at a time. A mode input chooses the direction. In encode mode the engine pushes words and the host pops them. In decode mode the host pushes words and the engine pops them. The block derives a stop flag, a service-request flag and a sticky error flag from the queue occupancy and the accesses made to it. These flags, three event inputs and a memory-fault input form a 16-bit status and interrupt-enable register. A single registered interrupt output combines every status bit whose enable is set.

The meaning of each flag depends on the direction. In encode mode, stop means there is nothing left to read. In decode mode, stop rises while a margin of 32 free slots is still left. This lets the host finish a 32-word burst after it sees stop without losing data. Changing the mode flushes the queue.

Top module: `hostFifoIrq`

## Requirements
- R1: After reset the queue is empty, all enables are 0, the error flag is 0 and `irqOut` is 0. Because mode 0 is encode, `regRdData` reads 16'h0020.
- R2: Words leave in the order they were accepted. The head word appears on `hostRdData` in encode mode and on `coreRdData` in decode mode, whenever the queue is not empty.
- R3: In encode mode (`modeDecode`=0), stop (status bit 5) is 1 exactly when the queue holds 0 words. Service request (status bit 3) is 1 when occupancy is at least DEPTH/2.
- R4: In decode mode, stop is 1 when occupancy is at least DEPTH-32. Service request is 1 when occupancy is at most DEPTH/2.
- R5: The error flag (status bit 4) sets on a push into a full queue, and that word is discarded. In decode mode it also sets on an engine pop from an empty queue. A host pop from an empty queue in encode mode does nothing.
- R6: The error flag stays set until a register write with data bit 4 = 1. If a new error happens in the same cycle as the clearing write, the flag stays set.
- R7: `stopPin` equals status bit 5 and `errPin` equals status bit 4.
- R8: Status bit 6 follows `memErrIn` and needs no host action to clear. Bits 0, 1 and 2 follow `vidErrIn`, `statRdyIn` and `lastCodeIn`.
- R9: A register write loads bits 14:8 as the enables. The enable in bit k+8 belongs to status bit k. Bits 7 and 15 always read 0, and writing them has no effect.
- R10: `irqOut` is 1 in the cycle after any status bit k and enable k+8 are both 1, and 0 otherwise.
- R11: When `modeDecode` changes, the next clock edge empties the queue and ignores all push and pop requests in that cycle. The error flag and the enables keep their values. The flags then use the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeDecode | input | 1 | 0 = encode, 1 = decode |
| hostWrEn | input | 1 | Host push request (decode) |
| hostWrData | input | 32 | Host push word |
| hostRdEn | input | 1 | Host pop request (encode) |
| hostRdData | output | 32 | Head word toward the host |
| coreWrEn | input | 1 | Engine push request (encode) |
| coreWrData | input | 32 | Engine push word |
| coreRdEn | input | 1 | Engine pop request (decode) |
| coreRdData | output | 32 | Head word toward the engine |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Status and enable read value |
| vidErrIn | input | 1 | Video data error level |
| statRdyIn | input | 1 | Statistics ready level |
| lastCodeIn | input | 1 | Last code read level |
| memErrIn | input | 1 | Memory-side fault level |
| stopPin | output | 1 | Stop flag pin |
| errPin | output | 1 | Error flag pin |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
The bench goes after the edges of the decode early-stop window. A threshold off by one would raise stop at the wrong word count during a host burst. It also drives pushes into a full queue, including a push and a pop in the same full cycle. A design that let that write through would corrupt the order of later words instead of flagging the error. The bench clears the error flag in the same cycle as a new overflow, where a wrong priority would lose the error. It switches mode with data still queued, where a missing flush would hand stale words to the other side.

// File: rtl/hfPkg.sv
package hfPkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic errSet;
  } hfStrobeT;

  localparam int ST_VID  = 0;
  localparam int ST_STAT = 1;
  localparam int ST_LAST = 2;
  localparam int ST_SVC  = 3;
  localparam int ST_ERR  = 4;
  localparam int ST_STOP = 5;
  localparam int ST_MEM  = 6;
  localparam int NSRC    = 7;
endpackage

// File: rtl/hfDatapath.sv
module hfDatapath
  import hfPkg::*;
#(
  parameter int DEPTH = 128,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  hfStrobeT         strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> count != '0);
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> count == '0);
endmodule

// File: rtl/hfControl.sv
module hfControl
  import hfPkg::*;
#(
  parameter int DEPTH = 128,
  parameter int STOP_MARGIN = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modeDecode,
  input  logic          hostWrEn,
  input  logic          hostRdEn,
  input  logic          coreWrEn,
  input  logic          coreRdEn,
  input  logic [CW-1:0] count,
  input  logic          regWrEn,
  input  logic [15:0]   regWrData,
  input  logic          vidErrIn,
  input  logic          statRdyIn,
  input  logic          lastCodeIn,
  input  logic          memErrIn,
  output hfStrobeT      strobe,
  output logic          modeQ,
  output logic [15:0]   regRdData,
  output logic          stopFlag,
  output logic          errFlag,
  output logic          irqOut
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);
  localparam logic [CW-1:0] STOP_LVL = CW'(DEPTH - STOP_MARGIN);

  logic [NSRC-1:0] enables, status;
  logic flushNow, wrReq, rdReq, isFull, isEmpty, svcFlag, errClr;
  logic unusedRegBits;

  assign unusedRegBits = ^{regWrData[15], regWrData[7:5], regWrData[3:0]};

  assign flushNow = modeDecode != modeQ;
  assign wrReq    = modeQ ? hostWrEn : coreWrEn;
  assign rdReq    = modeQ ? coreRdEn : hostRdEn;
  assign isFull   = count == FULL_LVL;
  assign isEmpty  = count == '0;

  always_comb begin
    strobe.flush  = flushNow;
    strobe.push   = !flushNow && wrReq && !isFull;
    strobe.pop    = !flushNow && rdReq && !isEmpty;
    strobe.errSet = !flushNow && ((wrReq && isFull) || (modeQ && coreRdEn && isEmpty));
  end

  assign stopFlag = modeQ ? (count >= STOP_LVL) : isEmpty;
  assign svcFlag  = modeQ ? (count <= HALF_LVL) : (count >= HALF_LVL);
  assign errClr   = regWrEn && regWrData[ST_ERR];

  always_comb begin
    status          = '0;
    status[ST_VID]  = vidErrIn;
    status[ST_STAT] = statRdyIn;
    status[ST_LAST] = lastCodeIn;
    status[ST_SVC]  = svcFlag;
    status[ST_ERR]  = errFlag;
    status[ST_STOP] = stopFlag;
    status[ST_MEM]  = memErrIn;
  end

  assign regRdData = {1'b0, enables, 1'b0, status};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      errFlag <= 1'b0;
      enables <= '0;
      irqOut  <= 1'b0;
    end else begin
      modeQ  <= modeDecode;
      irqOut <= |(status & enables);
      if (regWrEn) enables <= regWrData[14:8];
      if (strobe.errSet)  errFlag <= 1'b1;
      else if (errClr)    errFlag <= 1'b0;
    end
  end

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !errClr |=> errFlag);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.errSet |=> errFlag);
  a_r10_irq_raise: assert property (@(posedge clk) disable iff (!rstN)
    |(regRdData[6:0] & regRdData[14:8]) |=> irqOut);
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(|(regRdData[6:0] & regRdData[14:8])) |=> !irqOut);
  a_r11_flush_quiet: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |-> !strobe.push && !strobe.pop && !strobe.errSet);
endmodule

// File: rtl/hostFifoIrq.sv
module hostFifoIrq
  import hfPkg::*;
#(
  parameter int DEPTH = 128,
  parameter int WIDTH = 32,
  parameter int STOP_MARGIN = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeDecode,
  input  logic             hostWrEn,
  input  logic [WIDTH-1:0] hostWrData,
  input  logic             hostRdEn,
  output logic [WIDTH-1:0] hostRdData,
  input  logic             coreWrEn,
  input  logic [WIDTH-1:0] coreWrData,
  input  logic             coreRdEn,
  output logic [WIDTH-1:0] coreRdData,
  input  logic             regWrEn,
  input  logic [15:0]      regWrData,
  output logic [15:0]      regRdData,
  input  logic             vidErrIn,
  input  logic             statRdyIn,
  input  logic             lastCodeIn,
  input  logic             memErrIn,
  output logic             stopPin,
  output logic             errPin,
  output logic             irqOut
);
  hfStrobeT strobe;
  logic modeQ;
  logic [CW-1:0] count;
  logic [WIDTH-1:0] headData;

  hfControl #(.DEPTH(DEPTH), .STOP_MARGIN(STOP_MARGIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeDecode(modeDecode),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .coreWrEn(coreWrEn), .coreRdEn(coreRdEn), .count(count),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .vidErrIn(vidErrIn), .statRdyIn(statRdyIn),
    .lastCodeIn(lastCodeIn), .memErrIn(memErrIn),
    .strobe(strobe), .modeQ(modeQ), .regRdData(regRdData),
    .stopFlag(stopPin), .errFlag(errPin), .irqOut(irqOut)
  );

  hfDatapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(modeQ ? hostWrData : coreWrData),
    .headData(headData), .count(count)
  );

  assign hostRdData = headData;
  assign coreRdData = headData;

  a_r7_pins: assert property (@(posedge clk) disable iff (!rstN)
    stopPin == regRdData[5] && errPin == regRdData[4]);
endmodule

// File: tb/hostFifoIrq_bench.sv
module hostFifoIrq_bench;
  localparam int DEPTH = 128;

  logic clk = 1'b0, rstN = 1'b0;
  logic modeDecode = 0, hostWrEn = 0, hostRdEn = 0, coreWrEn = 0, coreRdEn = 0;
  logic [31:0] hostWrData = 0, coreWrData = 0, hostRdData, coreRdData;
  logic regWrEn = 0;
  logic [15:0] regWrData = 0, regRdData;
  logic vidErrIn = 0, statRdyIn = 0, lastCodeIn = 0, memErrIn = 0;
  logic stopPin, errPin, irqOut;

  always #4 clk = ~clk;

  hostFifoIrq u_hostFifoIrq (
    .clk(clk), .rstN(rstN), .modeDecode(modeDecode),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .coreWrEn(coreWrEn), .coreWrData(coreWrData), .coreRdEn(coreRdEn), .coreRdData(coreRdData),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .vidErrIn(vidErrIn), .statRdyIn(statRdyIn), .lastCodeIn(lastCodeIn), .memErrIn(memErrIn),
    .stopPin(stopPin), .errPin(errPin), .irqOut(irqOut)
  );

  int checks = 0, fails = 0;
  logic [31:0] q[$];
  bit mMode = 0, mErr = 0, mIrq = 0;
  bit [6:0] mEn = 0;
  int dataVal = 1;
  bit finished = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [6:0] mStatus();
    int n = q.size();
    bit [6:0] s;
    s[0] = vidErrIn; s[1] = statRdyIn; s[2] = lastCodeIn;
    s[3] = mMode ? (n <= DEPTH / 2) : (n >= DEPTH / 2);
    s[4] = mErr;
    s[5] = mMode ? (n >= DEPTH - 32) : (n == 0);
    s[6] = memErrIn;
    return s;
  endfunction

  task automatic compareAll();
    bit [6:0] st = mStatus();
    string sTag = mMode ? "R4" : "R3";
    check("R9", regRdData, {1'b0, mEn, 1'b0, st});
    check(sTag, stopPin, st[5]);
    check(sTag, regRdData[3], st[3]);
    check("R6", errPin, mErr);
    check("R7", stopPin, regRdData[5]);
    check("R7", errPin, regRdData[4]);
    check("R10", irqOut, mIrq);
    if (q.size() > 0) check("R2", mMode ? coreRdData : hostRdData, q[0]);
  endtask

  task automatic tick();
    bit nIrq = |(mStatus() & mEn);
    bit errSet = 0;
    if (modeDecode != mMode) begin
      q.delete();
      mMode = modeDecode;
    end else begin
      int n = q.size();
      bit wr = mMode ? hostWrEn : coreWrEn;
      bit rd = mMode ? coreRdEn : hostRdEn;
      logic [31:0] wd = mMode ? hostWrData : coreWrData;
      errSet = (wr && n == DEPTH) || (mMode && coreRdEn && n == 0);
      if (rd && n > 0) void'(q.pop_front());
      if (wr && n < DEPTH) q.push_back(wd);
    end
    if (errSet) mErr = 1;
    else if (regWrEn && regWrData[4]) mErr = 0;
    if (regWrEn) mEn = regWrData[14:8];
    mIrq = nIrq;
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    hostWrEn = 0; hostRdEn = 0; coreWrEn = 0; coreRdEn = 0; regWrEn = 0;
  endtask

  task automatic regWrite(logic [15:0] d);
    regWrEn = 1; regWrData = d; tick(); regWrEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R1", regRdData, 16'h0020);
    check("R1", irqOut, 0);
    check("R1", errPin, 0);
    // R9: reserved bits 7 and 15 ignored
    regWrite(16'hFFFF);
    check("R9", regRdData[15], 0);
    check("R9", regRdData[7], 0);
    // encode fill past capacity: R5
    for (int i = 0; i < DEPTH + 2; i++) begin
      coreWrEn = 1; coreWrData = dataVal++; tick();
    end
    check("R5", errPin, 1);
    // simultaneous push and pop starting from full
    for (int i = 0; i < 20; i++) begin
      coreWrEn = 1; coreWrData = dataVal++; hostRdEn = 1; tick();
    end
    idle();
    regWrite(16'h7F10);
    check("R6", errPin, 0);
    coreWrEn = 1; coreWrData = dataVal++; tick();
    // overflow and clear in the same cycle: set wins
    coreWrData = dataVal++; regWrEn = 1; regWrData = 16'h7F10; tick();
    idle();
    check("R6", errPin, 1);
    regWrite(16'h7F10);
    // drain in encode, with extra reads on empty
    for (int i = 0; i < DEPTH + 3; i++) begin
      hostRdEn = 1; tick();
    end
    idle();
    check("R5", errPin, 0);
    check("R3", stopPin, 1);
    // level status inputs: R8
    memErrIn = 1; tick();
    check("R8", regRdData[6], 1);
    memErrIn = 0; vidErrIn = 1; statRdyIn = 1; lastCodeIn = 1; tick();
    check("R8", regRdData[6], 0);
    check("R8", regRdData[2:0], 3'b111);
    vidErrIn = 0; statRdyIn = 0; lastCodeIn = 0;
    regWrite(16'h0000);
    tick();
    check("R10", irqOut, 0);
    regWrite(16'h6000);
    // queued data then mode change: R11
    for (int i = 0; i < 5; i++) begin
      coreWrEn = 1; coreWrData = dataVal++; tick();
    end
    idle();
    coreWrEn = 1; coreWrData = dataVal++;
    modeDecode = 1; tick();
    idle();
    check("R11", regRdData[3], 1);
    check("R11", stopPin, 0);
    // decode burst up to the early stop and past capacity
    for (int i = 0; i < DEPTH + 2; i++) begin
      hostWrEn = 1; hostWrData = dataVal++; tick();
      if (i == DEPTH - 34) check("R4", stopPin, 0);
      if (i == DEPTH - 33) check("R4", stopPin, 1);
    end
    idle();
    check("R5", errPin, 1);
    regWrite(16'h6010);
    for (int i = 0; i < DEPTH + 2; i++) begin
      coreRdEn = 1; tick();
    end
    idle();
    check("R5", errPin, 1);
    regWrite(16'h6010);
    for (int i = 0; i < 7; i++) begin
      hostWrEn = 1; hostWrData = dataVal++; tick();
    end
    idle();
    modeDecode = 0; tick();
    check("R11", stopPin, 1);
    check("R11", errPin, 0);
    repeat (3) tick();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule